// File: doc/BRIEF.md
# Voice Enhancer Control Port

This block is the two-wire serial control port of a voice-enhancement engine. A host writes short command transfers to it, and the block keeps the control state that the audio path consumes. That state is the processing mode, the enhancement strength, four equalizer band gains and a noise-gate threshold. A host read returns a byte that a prior query command selected: either a packed status byte or the level of one equalizer band.

Both bus lines are resynchronised to the system clock and cleaned by a three-sample majority vote before any edge is decoded. Start and stop conditions frame each transfer. The device address is 7 bits, and its low bit comes from a strap pin. A write carries a command byte and, for some commands, one data byte. The slave acknowledges every byte addressed to it, including commands it does not recognise. The register values leave the block on plain output pins. No stream interface exists, so the outputs need no handshake: they change only when a command byte or data byte completes. The SDA pin is open-drain, and `sda_oe` high pulls the line low.

Top module: `vc_i2c_ctl`

## Requirements
- R1: The slave answers an address byte equal to {6'b100000, addr_sel, rw}, so that with addr_sel low it answers 0x80 for a write and 0x81 for a read. It acknowledges each byte of a matching transfer by pulling SDA low, and it leaves SDA released for any other address.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The slave changes its SDA drive only while filtered SCL is low.
- R3: Command 0x01 sets the DSP-off flag, which is also the reset state. Command 0x02 clears the flag and selects enhancement mode (mode bit 0). Command 0x03 clears the flag and selects equalizer mode (mode bit 1).
- R4: Command 0x09 with a data byte of 0, 1 or 2 sets the level code. Code 0 means 100%, 1 means 80% and 2 means 60%. Any larger data byte leaves the level unchanged.
- R5: Commands 0x04 to 0x08 load band gains in dB, given as band1/2/3/4. Flat (0x04) is 0/0/0/0. 0x05 is +3/-1/-1/+1. 0x06 is +3/0/0/+3. 0x07 is +5/0/0/0. 0x08 is +5/0/0/+1. Each gain output carries the code 12 minus the dB value.
- R6: Command 0x0D with a data byte sets the noise threshold to that byte.
- R7: Command 0x0E with data 0x01 selects the status byte for reads. Its bits are {4'b0, level[1:0], mode, dsp_off}. Status is also the selection after reset.
- R8: Command 0x0E with data 0x02 to 0x05 selects reads of band 1 to 4. Those reads return 24 minus the band code, so 0x00 means -12 dB and 0x18 means +12 dB.
- R9: Command 0x0A with a data byte sets one band gain. Data bits [7:5] hold the band index (0 to 3), and bits [4:0] hold the code, where 0 is +12 dB, 12 is 0 dB and 24 is -12 dB. A band index above 3 or a code above 24 changes nothing.
- R10: An active-low reset restores the defaults. These are DSP off, enhancement mode, level code 1, band codes 8/12/12/11 (+4/0/0/+1 dB) and noise threshold 0x1F.
- R11: An unrecognised command, or a data byte that follows a command taking none, is acknowledged but changes no output.
- R12: A pulse on SDA or SCL that lasts a single system clock is filtered out and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap for the low bit of the device address |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | Pulls SDA low when high |
| dsp_off | output | 1 | Processing disabled, audio passes through |
| eq_mode | output | 1 | 0 selects enhancement, 1 selects equalizer |
| enh_level | output | 2 | Enhancement level code |
| band_gain | output | 20 | Four 5-bit band gain codes, band 1 in bits [4:0] |
| noise_thr | output | 8 | Noise-gate threshold |

## Verification
The assertions watch several properties on every cycle. The level code never takes its unused value, and no band code leaves the range 0 to 24. The slave begins pulling SDA only while filtered SCL is low, and the registers hold their defaults on the first cycle after reset. Everything that depends on the content of a transfer can only be shown by the bench's scenarios. This covers address matching against the strap, each command's effect, the rejection of bad data bytes, the inverted band readback, and the survival of a transfer through a one-clock glitch.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int NBANDS   = 4;
  localparam int GAIN_W   = 5;
  localparam int SYNC_LEN = 2;
  localparam int VOTE_LEN = 3;
  localparam logic [4:0] GAIN_MAX   = 5'd24;
  localparam logic [7:0] NOISE_INIT = 8'h1F;
  localparam logic [1:0] LEVEL_INIT = 2'd1;
  localparam logic [5:0] ADDR_HI    = 6'b100000;

  localparam logic [7:0] OP_BYPASS = 8'h01;
  localparam logic [7:0] OP_ENH    = 8'h02;
  localparam logic [7:0] OP_EQ     = 8'h03;
  localparam logic [7:0] OP_PFIRST = 8'h04;
  localparam logic [7:0] OP_PLAST  = 8'h08;
  localparam logic [7:0] OP_LEVEL  = 8'h09;
  localparam logic [7:0] OP_BAND   = 8'h0A;
  localparam logic [7:0] OP_NOISE  = 8'h0D;
  localparam logic [7:0] OP_QUERY  = 8'h0E;

  typedef enum logic [2:0] {
    BS_IDLE, BS_RECV, BS_ACKO, BS_SEND, BS_ACKI
  } bus_st_t;

  // gain code (12 - dB) for a preset opcode and band
  function automatic logic [4:0] preset_code(input logic [7:0] op, input int band);
    logic [4:0] c;
    c = 5'd12;
    case (op)
      8'h05: c = (band == 0) ? 5'd9 : (band == 3) ? 5'd11 : 5'd13;
      8'h06: c = (band == 0 || band == 3) ? 5'd9 : 5'd12;
      8'h07: c = (band == 0) ? 5'd7 : 5'd12;
      8'h08: c = (band == 0) ? 5'd7 : (band == 3) ? 5'd11 : 5'd12;
      default: c = 5'd12;
    endcase
    return c;
  endfunction

  function automatic logic [4:0] init_code(input int band);
    return (band == 0) ? 5'd8 : (band == 3) ? 5'd11 : 5'd12;
  endfunction
endpackage

// File: rtl/vc_line_filter.sv
module vc_line_filter #(
  parameter int SYNC = 2,
  parameter int VOTE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int HALF = VOTE / 2;

  logic [SYNC-1:0] sync_q;
  logic [VOTE-1:0] win_q;
  int unsigned ones;

  always_comb begin
    ones = 0;
    for (int i = 0; i < VOTE; i++) ones = ones + int'(win_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw};
      win_q  <= {win_q[VOTE-2:0], sync_q[SYNC-1]};
      clean  <= (ones > HALF);
    end
  end
endmodule

// File: rtl/vc_i2c_engine.sv
module vc_i2c_engine
  import vc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_byte,
  output logic       wr_stb,
  output logic [1:0] byte_pos,
  output logic [7:0] wr_byte,
  output logic       sda_oe
);
  bus_st_t    st;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       is_addr, rd_mode, nack;

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire bus_start = scl_f & scl_q & sda_q & ~sda_f;
  wire bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BS_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      cnt <= '0; sh <= '0; tx <= '0;
      is_addr <= 1'b0; rd_mode <= 1'b0; nack <= 1'b0;
      wr_stb <= 1'b0; byte_pos <= '0; wr_byte <= '0; sda_oe <= 1'b0;
    end else begin
      scl_q  <= scl_f;
      sda_q  <= sda_f;
      wr_stb <= 1'b0;
      if (bus_start) begin
        st <= BS_RECV; cnt <= '0; is_addr <= 1'b1;
        byte_pos <= '0; sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st <= BS_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          BS_RECV: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (is_addr) begin
                if (sh[7:1] == dev_addr) begin
                  rd_mode <= sh[0]; sda_oe <= 1'b1; st <= BS_ACKO;
                end else begin
                  st <= BS_IDLE;
                end
              end else begin
                wr_stb <= 1'b1; wr_byte <= sh; sda_oe <= 1'b1; st <= BS_ACKO;
              end
            end
          end
          BS_ACKO: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              if (!is_addr && byte_pos != 2'd2) byte_pos <= byte_pos + 2'd1;
              if (rd_mode) begin
                tx <= {rd_byte[6:0], 1'b0}; sda_oe <= ~rd_byte[7];
                cnt <= 4'd1; st <= BS_SEND;
              end else begin
                sda_oe <= 1'b0; cnt <= '0; st <= BS_RECV;
              end
            end
          end
          BS_SEND: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= BS_ACKI;
              end else begin
                sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
              end
            end
          end
          BS_ACKI: begin
            if (scl_rise) begin
              nack <= sda_f;
            end else if (scl_fall) begin
              if (nack) begin
                st <= BS_IDLE;
              end else begin
                tx <= {rd_byte[6:0], 1'b0}; sda_oe <= ~rd_byte[7];
                cnt <= 4'd1; st <= BS_SEND;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vc_cmd_regs.sv
module vc_cmd_regs
  import vc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [1:0]               byte_pos,
  input  logic [7:0]               wr_byte,
  output logic [7:0]               rd_byte,
  output logic                     dsp_off,
  output logic                     eq_mode,
  output logic [1:0]               enh_level,
  output logic [NBANDS*GAIN_W-1:0] band_gain,
  output logic [7:0]               noise_thr
);
  logic [GAIN_W-1:0] gain_q [NBANDS];
  logic [7:0]        op_q;
  logic [2:0]        qsel_q;

  wire is_preset = (wr_byte >= OP_PFIRST) && (wr_byte <= OP_PLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp_off <= 1'b1; eq_mode <= 1'b0; enh_level <= LEVEL_INIT;
      noise_thr <= NOISE_INIT; op_q <= '0; qsel_q <= 3'd1;
      for (int b = 0; b < NBANDS; b++) gain_q[b] <= init_code(b);
    end else if (wr_stb) begin
      if (byte_pos == 2'd0) begin
        op_q <= wr_byte;
        case (wr_byte)
          OP_BYPASS: dsp_off <= 1'b1;
          OP_ENH: begin dsp_off <= 1'b0; eq_mode <= 1'b0; end
          OP_EQ:  begin dsp_off <= 1'b0; eq_mode <= 1'b1; end
          default: begin
            if (is_preset)
              for (int b = 0; b < NBANDS; b++) gain_q[b] <= preset_code(wr_byte, b);
          end
        endcase
      end else if (byte_pos == 2'd1) begin
        case (op_q)
          OP_LEVEL: if (wr_byte <= 8'd2) enh_level <= wr_byte[1:0];
          OP_BAND: begin
            for (int b = 0; b < NBANDS; b++)
              if (wr_byte[7:5] == 3'(b) && wr_byte[4:0] <= GAIN_MAX)
                gain_q[b] <= wr_byte[4:0];
          end
          OP_NOISE: noise_thr <= wr_byte;
          OP_QUERY: if (wr_byte >= 8'd1 && wr_byte <= 8'(NBANDS + 1)) qsel_q <= wr_byte[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_byte = {4'b0, enh_level, eq_mode, dsp_off};
    for (int b = 0; b < NBANDS; b++) begin
      band_gain[b*GAIN_W +: GAIN_W] = gain_q[b];
      if (qsel_q == 3'(b + 2)) rd_byte = 8'(GAIN_MAX - gain_q[b]);
    end
  end
endmodule

// File: rtl/vc_i2c_ctl.sv
module vc_i2c_ctl
  import vc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_sel,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_oe,
  output logic                     dsp_off,
  output logic                     eq_mode,
  output logic [1:0]               enh_level,
  output logic [NBANDS*GAIN_W-1:0] band_gain,
  output logic [7:0]               noise_thr
);
  logic [1:0] raw_lines, clean_lines;
  logic       scl_f, sda_f;
  logic       wr_stb;
  logic [1:0] byte_pos;
  logic [7:0] wr_byte, rd_byte;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    vc_line_filter #(.SYNC(SYNC_LEN), .VOTE(VOTE_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .clean(clean_lines[g])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  vc_i2c_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .dev_addr({ADDR_HI, addr_sel}), .rd_byte(rd_byte),
    .wr_stb(wr_stb), .byte_pos(byte_pos), .wr_byte(wr_byte), .sda_oe(sda_oe)
  );

  vc_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .byte_pos(byte_pos),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .dsp_off(dsp_off), .eq_mode(eq_mode),
    .enh_level(enh_level), .band_gain(band_gain), .noise_thr(noise_thr)
  );
endmodule

// File: rtl/vc_i2c_ctl_chk.sv
module vc_i2c_ctl_chk
  import vc_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_f,
  input logic                     sda_oe,
  input logic                     dsp_off,
  input logic                     eq_mode,
  input logic [1:0]               enh_level,
  input logic [NBANDS*GAIN_W-1:0] band_gain,
  input logic [7:0]               noise_thr
);
  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    enh_level != 2'b11); // R4

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R2

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dsp_off && !eq_mode && enh_level == LEVEL_INIT
                      && noise_thr == NOISE_INIT)); // R10

  for (genvar b = 0; b < NBANDS; b++) begin : g_rng
    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      band_gain[b*GAIN_W +: GAIN_W] <= GAIN_MAX); // R9
  end
endmodule

bind vc_i2c_ctl vc_i2c_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .dsp_off(dsp_off), .eq_mode(eq_mode), .enh_level(enh_level),
  .band_gain(band_gain), .noise_thr(noise_thr)
);

// File: tb/vc_i2c_ctl_test.sv
module vc_i2c_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, dsp_off, eq_mode;
  logic [1:0] enh_level;
  logic [19:0] band_gain;
  logic [7:0] noise_thr;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_code [4];
  logic [1:0] exp_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_i2c_ctl uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .dsp_off(dsp_off), .eq_mode(eq_mode), .enh_level(enh_level),
    .band_gain(band_gain), .noise_thr(noise_thr)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    sda_m = b; wait_clk(H); scl_m = 1'b1; wait_clk(H/2);
    if (glitch) begin sda_m = ~b; wait_clk(1); sda_m = b; end
    wait_clk(H/2); scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(H); sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H); scl_m = 1'b1; wait_clk(H); sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gpos, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i], i == gpos);
    sda_m = 1'b1; wait_clk(H); scl_m = 1'b1; wait_clk(H/2);
    ack = ~sda_bus; wait_clk(H/2); scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic read_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H); scl_m = 1'b1; wait_clk(H/2); b[i] = sda_bus;
      wait_clk(H/2); scl_m = 1'b0; wait_clk(2);
    end
    bit_out(1'b1, 0);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] op, input bit has_d,
                    input logic [7:0] d, input int gpos, output bit ok);
    bit a;
    bus_start();
    send_byte(addr, -1, a); ok = a;
    if (a) begin
      send_byte(op, -1, a); ok &= a;
      if (has_d) begin send_byte(d, gpos, a); ok &= a; end
    end
    bus_stop(); wait_clk(4);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] b, output bit ok);
    bus_start(); send_byte(addr, -1, ok);
    b = 8'hFF;
    if (ok) read_byte(b);
    bus_stop(); wait_clk(4);
  endtask

  task automatic check_gains(input string req);
    for (int b = 0; b < 4; b++) check(req, int'(band_gain[b*5 +: 5]), exp_code[b]);
  endtask

  function automatic int preset_db(input int op, input int band);
    int t [5][4] = '{'{0,0,0,0}, '{3,-1,-1,1}, '{3,0,0,3}, '{5,0,0,0}, '{5,0,0,1}};
    return t[op-4][band];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] rb;
    logic [19:0] snap_g;
    logic [7:0] snap_n;
    exp_code = '{8, 12, 12, 11};
    exp_lvl = 2'd1;
    wait_clk(12); rst_n = 1'b1; wait_clk(4);

    // R10 reset defaults
    check("R10 dsp_off", dsp_off, 1); check("R10 mode", eq_mode, 0);
    check("R10 level", enh_level, 1); check("R10 noise", noise_thr, 8'h1F);
    check("R10 sda_oe", sda_oe, 0); check_gains("R10 gains");

    // R7 status read after reset: level 1, mode 0, off 1 -> 0x05
    rd(8'h81, rb, ok); check("R1 read ack", ok, 1); check("R7 status default", rb, 8'h05);

    // R1 address matching against strap
    wr(8'h84, OP_NOISE_T(), 1, 8'h11, -1, ok); check("R1 foreign addr nack", ok, 0);
    wr(8'h82, 8'h0D, 1, 8'h11, -1, ok); check("R1 strap-high addr nack", ok, 0);
    check("R1 noise untouched", noise_thr, 8'h1F);
    addr_sel = 1'b1; wait_clk(4);
    wr(8'h82, 8'h0D, 1, 8'h44, -1, ok); check("R1 strap addr ack", ok, 1);
    check("R6 noise via strap addr", noise_thr, 8'h44);
    wr(8'h80, 8'h0D, 1, 8'h55, -1, ok); check("R1 old addr nack", ok, 0);
    addr_sel = 1'b0; wait_clk(4);

    // R3 mode commands and R7 status encoding
    wr(8'h80, 8'h02, 0, 0, -1, ok); check("R3 enh ack", ok, 1);
    check("R3 enh off", dsp_off, 0); check("R3 enh mode", eq_mode, 0);
    wr(8'h80, 8'h03, 0, 0, -1, ok);
    check("R3 eq off", dsp_off, 0); check("R3 eq mode", eq_mode, 1);
    wr(8'h80, 8'h0E, 1, 8'h01, -1, ok); rd(8'h81, rb, ok);
    check("R7 status eq", rb, {4'b0, exp_lvl, 1'b1, 1'b0});

    // R4 level sweep, value 3 rejected
    for (int d = 0; d < 4; d++) begin
      wr(8'h80, 8'h09, 1, 8'(d), -1, ok);
      if (d <= 2) exp_lvl = 2'(d);
      check("R4 level", enh_level, exp_lvl);
    end
    rd(8'h81, rb, ok); check("R7 status level", rb, {4'b0, exp_lvl, 1'b1, 1'b0});

    // R5 presets
    for (int op = 4; op <= 8; op++) begin
      wr(8'h80, 8'(op), 0, 0, -1, ok);
      for (int b = 0; b < 4; b++) exp_code[b] = 12 - preset_db(op, b);
      check_gains("R5 preset");
    end

    // R9 band write sweep
    for (int sel = 0; sel < 8; sel++) begin
      for (int c = 0; c < 32; c++) begin
        if (sel >= 4 && c != 3) continue;
        wr(8'h80, 8'h0A, 1, {3'(sel), 5'(c)}, -1, ok);
        if (sel < 4 && c <= 24) exp_code[sel] = c;
        check_gains("R9 band write");
      end
    end

    // R8 band readback on the inverted scale
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 3; k++) begin
        wr(8'h80, 8'h0A, 1, {3'(b), 5'(k * 12)}, -1, ok); exp_code[b] = k * 12;
        wr(8'h80, 8'h0E, 1, 8'(b + 2), -1, ok);
        rd(8'h81, rb, ok);
        check("R8 band level", rb, 12 + (12 - k * 12));
      end
    end
    wr(8'h80, 8'h0E, 1, 8'h01, -1, ok);

    // R6 noise threshold
    wr(8'h80, 8'h0D, 1, 8'hA7, -1, ok); check("R6 noise", noise_thr, 8'hA7);

    // R11 unknown commands acknowledged, no effect
    snap_g = band_gain; snap_n = noise_thr;
    wr(8'h80, 8'h0F, 1, 8'h00, -1, ok); check("R11 unknown ack", ok, 1);
    wr(8'h80, 8'h00, 1, 8'h12, -1, ok); check("R11 zero op ack", ok, 1);
    wr(8'h80, 8'h02, 1, 8'h01, -1, ok);
    wr(8'h80, 8'h03, 0, 0, -1, ok);
    check("R11 gains kept", band_gain, snap_g); check("R11 noise kept", noise_thr, snap_n);
    check("R11 level kept", enh_level, exp_lvl); check("R11 mode kept", eq_mode, 1);
    rd(8'h81, rb, ok); check("R11 status kept", rb, {4'b0, exp_lvl, 1'b1, 1'b0});

    // R12 one-clock SDA glitch while SCL high, data 0x33 bit 5 is a one
    wr(8'h80, 8'h0D, 1, 8'h33, 5, ok); check("R12 glitch ack", ok, 1);
    check("R12 glitch noise", noise_thr, 8'h33);

    // R3 back to bypass, R2 framing: a stop then fresh transfer works
    wr(8'h80, 8'h01, 0, 0, -1, ok); check("R3 bypass", dsp_off, 1);
    check("R2 released after stop", sda_oe, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] OP_NOISE_T();
    return 8'h0D;
  endfunction
endmodule